// File: doc/BRIEF.md
# Key-Restarted Watchdog Timer

This block is a free-running watchdog down-counter advanced by a slow timebase pulse, one pulse for each 100 ms period. Software sets it up through a small write/read register port with an 8-bit data path. A configuration register holds a 5-bit period code and an enable bit. A separate kick register restarts the timer, but only when a fixed 4-bit key lands in its low nibble. That kick is also the only way a newly programmed period reaches the counter.

When the count runs out and the enable bit is set, the block raises a reset request. The request lasts for one timebase period, or ends earlier if the sensed system reset line goes low. A rising edge on that sensed line reloads the counter, so the next period starts fresh after every reset pulse. A supply-good input silences the watchdog while the supply is below its trip point. The all-ones period code parks the counter completely.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, reading address 0x0A returns 0x1E (enable 0, period code 30) and the reset request is low.
- R2: Address 0x0A is read/write. Bit 7 is the enable, bits 4:0 are the period code, and bits 6:5 read as 0. Reading any other address returns 0.
- R3: A write whose low nibble is 1010b to address 0x09 (upper nibble ignored) loads the counter with the current period code, where code 0 counts as 1. With the enable set, the request rises on exactly that many timebase pulses after the write.
- R4: Writes to 0x09 with any other low nibble, and writes to the period code without a key write, leave the running count unchanged.
- R5: The counter decrements and reloads whether or not the enable is set. A request is raised only if the enable is set at the pulse that expires the count. On expiry the counter reloads with the last keyed period.
- R6: While the programmed period code is 31, timebase pulses do not change the count.
- R7: Once raised, the request stays high until the next timebase pulse, or until the sensed reset line reads low.
- R8: A rising edge on the sensed reset line reloads the counter with the last keyed period.
- R9: While supply-good is low, timebase pulses are ignored and the request is held low.
- R10: A key write and a timebase pulse in the same clock cycle leave the counter at the reloaded value; the pulse is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle timebase pulse, one per 100 ms |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for both reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| supply_ok_i | input | 1 | High while the supply is above the trip point |
| rst_pin_n_i | input | 1 | Sensed level of the system reset line, asynchronous |
| wd_reset_o | output | 1 | Watchdog reset request |

## Verification
On every cycle, the assertions check the following: the request rises only on an enabled, powered pulse with the reset line high; a low supply or a low sensed line forces the request down; a parked counter holds its count; a key write lands the expected reload value; and the count never reaches zero. The bench sweeps every period code and checks that the request appears on exactly the right pulse. Only the bench scenarios can show the cross-register behaviours: a period change without a key, a run while disabled that is then enabled, a reload on the reset line's edge, and a key write colliding with a pulse.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int CODE_W = 5;
  localparam int DATA_W = 8;
  localparam logic [CODE_W-1:0] CODE_PARK  = '1;
  localparam logic [CODE_W-1:0] CODE_RESET = CODE_PARK - 1'b1;
  localparam logic [3:0]        KICK_KEY   = 4'b1010;

  function automatic logic [CODE_W-1:0] eff_period(input logic [CODE_W-1:0] code);
    return (code == '0) ? CODE_W'(1) : code;
  endfunction
endpackage

// File: rtl/wdt_keyed_sync.sv
module wdt_keyed_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic rst_sync_n,
  output logic pin_s,
  output logic pin_rise
);
  logic [STAGES-1:0] rst_chain;
  logic [STAGES-1:0] pin_chain;
  logic              pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pin_chain <= '1;
      pin_prev  <= 1'b1;
    end else begin
      pin_chain <= {pin_chain[STAGES-2:0], pin_n_i};
      pin_prev  <= pin_chain[STAGES-1];
    end
  end
  assign pin_s    = pin_chain[STAGES-1];
  assign pin_rise = pin_s & ~pin_prev;
endmodule

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h0A,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 8'h09
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cfg_en,
  output logic [CODE_W-1:0] cfg_code,
  output logic              key_hit
);
  localparam int EN_BIT = DATA_W - 1;

  logic              cfg_we;
  logic              en_d;
  logic [CODE_W-1:0] code_d;

  assign cfg_we  = wr_en_i && (addr_i == CFG_ADDR);
  assign key_hit = wr_en_i && (addr_i == KICK_ADDR) && (wdata_i[3:0] == KICK_KEY);

  always_comb begin
    en_d   = cfg_en;
    code_d = cfg_code;
    if (cfg_we) begin
      en_d   = wdata_i[EN_BIT];
      code_d = wdata_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_en   <= 1'b0;
      cfg_code <= CODE_RESET;
    end else if (cfg_we) begin
      cfg_en   <= en_d;
      cfg_code <= code_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_ADDR) begin
      rdata_o[EN_BIT]       = cfg_en;
      rdata_o[CODE_W-1:0]   = cfg_code;
    end
  end
endmodule

// File: rtl/wdt_keyed_counter.sv
module wdt_keyed_counter
  import wdt_keyed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              tick_i,
  input  logic              supply_ok_i,
  input  logic              cfg_en,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              key_hit,
  input  logic              pin_s,
  input  logic              pin_rise,
  output logic [CODE_W-1:0] cnt_q,
  output logic              req_q
);
  logic [CODE_W-1:0] per_q, per_d, cnt_d;
  logic              req_d, expire, parked, step;

  assign parked = (cfg_code == CODE_PARK);
  assign step   = tick_i && supply_ok_i && !parked;

  always_comb begin
    per_d  = per_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (key_hit) begin
      per_d = eff_period(cfg_code);
      cnt_d = eff_period(cfg_code);
    end else if (pin_rise) begin
      cnt_d = per_q;
    end else if (step) begin
      if (cnt_q == CODE_W'(1)) begin
        cnt_d  = per_q;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    req_d = req_q;
    if (!supply_ok_i || !pin_s) req_d = 1'b0;
    else if (expire && cfg_en)  req_d = 1'b1;
    else if (tick_i)            req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      per_q <= CODE_RESET;
      cnt_q <= CODE_RESET;
      req_q <= 1'b0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              supply_ok_i,
  input  logic              rst_pin_n_i,
  output logic              wd_reset_o
);
  logic              rst_sync_n, pin_s, pin_rise;
  logic              cfg_en, key_hit;
  logic [CODE_W-1:0] cfg_code, cnt_q;

  wdt_keyed_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n_i(rst_pin_n_i),
    .rst_sync_n(rst_sync_n), .pin_s(pin_s), .pin_rise(pin_rise)
  );

  wdt_keyed_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_sync_n(rst_sync_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_en(cfg_en),
    .cfg_code(cfg_code), .key_hit(key_hit)
  );

  wdt_keyed_counter u_cnt (
    .clk(clk), .rst_sync_n(rst_sync_n), .tick_i(tick_i),
    .supply_ok_i(supply_ok_i), .cfg_en(cfg_en), .cfg_code(cfg_code),
    .key_hit(key_hit), .pin_s(pin_s), .pin_rise(pin_rise),
    .cnt_q(cnt_q), .req_q(wd_reset_o)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_keyed_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              tick_i,
  input logic              supply_ok_i,
  input logic              wd_reset_o,
  input logic              cfg_en,
  input logic [CODE_W-1:0] cfg_code,
  input logic              key_hit,
  input logic              pin_s,
  input logic              pin_rise,
  input logic [CODE_W-1:0] cnt_q
);
  // R5
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(wd_reset_o) |-> $past(tick_i && cfg_en && supply_ok_i && pin_s));

  // R9
  supply_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok_i |=> !wd_reset_o);

  // R7
  pin_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pin_s |=> !wd_reset_o);

  // R6
  parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_code == CODE_PARK && !key_hit && !pin_rise) |=> $stable(cnt_q));

  // R3
  key_reload_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_hit |=> (cnt_q == eff_period($past(cfg_code))));

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_q != '0);
endmodule

bind wdt_keyed_top wdt_keyed_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .tick_i(tick_i),
  .supply_ok_i(supply_ok_i), .wd_reset_o(wd_reset_o), .cfg_en(cfg_en),
  .cfg_code(cfg_code), .key_hit(key_hit), .pin_s(pin_s),
  .pin_rise(pin_rise), .cnt_q(cnt_q)
);

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       supply_ok = 1'b1;
  logic       pin_n = 1'b1;
  logic       wd_req;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_keyed_top dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .supply_ok_i(supply_ok),
    .rst_pin_n_i(pin_n), .wd_reset_o(wd_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // request must appear exactly on pulse n and not before
  task automatic expect_expiry(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      do_tick();
      check(req, wd_req, (i == n) ? 1 : 0);
    end
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      do_tick();
      check(req, wd_req, 0);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    addr = 8'h0A; @(negedge clk);
    check("R1", rdata, 8'h1E);
    check("R1", wd_req, 0);
    // R2 register map
    wr(8'h0A, 8'hE5);
    addr = 8'h0A; @(negedge clk);
    check("R2", rdata, 8'h85);
    addr = 8'h09; @(negedge clk);
    check("R2", rdata, 8'h00);
    wr(8'h0A, 8'h1F);
    addr = 8'h0A; @(negedge clk);
    check("R2", rdata, 8'h1F);
    addr = 8'h00;

    // R3 sweep every usable code
    for (int t = 0; t <= 30; t++) begin
      wr(8'h0A, 8'h80 | 8'(t));
      wr(8'h09, (t % 2 == 1) ? 8'h5A : 8'h0A);
      expect_expiry((t == 0) ? 1 : t, "R3");
    end

    // R7 request held between pulses, cleared by next pulse
    wr(8'h0A, 8'h83); wr(8'h09, 8'h0A);
    expect_expiry(3, "R7");
    idle(20);
    check("R7", wd_req, 1);
    do_tick();
    check("R7", wd_req, 0);

    // R4 other nibbles and bare code writes keep the count
    wr(8'h0A, 8'h85); wr(8'h09, 8'h0A);
    expect_quiet(2, "R4");
    wr(8'h0A, 8'h82);
    for (int v = 0; v < 16; v++)
      if (v != 10) wr(8'h09, 8'hF0 | 8'(v));
    expect_expiry(3, "R4");
    // R5 reload uses keyed period 5, not the bare code 2
    expect_expiry(5, "R5");

    // R5 running while disabled, then enabled mid-period
    wr(8'h0A, 8'h04); wr(8'h09, 8'h0A);
    expect_quiet(6, "R5");
    wr(8'h0A, 8'h84);
    expect_expiry(2, "R5");

    // R6 parked code
    wr(8'h0A, 8'h9F); wr(8'h09, 8'h0A);
    expect_quiet(40, "R6");
    wr(8'h0A, 8'h83);
    expect_expiry(31, "R6");

    // R7 low reset line clears request
    wr(8'h09, 8'h0A);
    expect_expiry(3, "R7");
    @(negedge clk); pin_n = 1'b0;
    idle(4);
    check("R7", wd_req, 0);
    // R8 rising edge of the line reloads
    @(negedge clk); pin_n = 1'b1;
    idle(6);
    wr(8'h0A, 8'h86); wr(8'h09, 8'h0A);
    expect_quiet(3, "R8");
    @(negedge clk); pin_n = 1'b0;
    idle(4);
    @(negedge clk); pin_n = 1'b1;
    idle(6);
    expect_expiry(6, "R8");

    // R9 supply low
    wr(8'h0A, 8'h83); wr(8'h09, 8'h0A);
    @(negedge clk); supply_ok = 1'b0;
    expect_quiet(5, "R9");
    @(negedge clk); supply_ok = 1'b1;
    expect_expiry(3, "R9");
    @(negedge clk); supply_ok = 1'b0;
    idle(2);
    check("R9", wd_req, 0);
    @(negedge clk); supply_ok = 1'b1;

    // R10 key and pulse in the same cycle
    wr(8'h0A, 8'h84); wr(8'h09, 8'h0A);
    expect_quiet(2, "R10");
    @(negedge clk); wr_en = 1'b1; addr = 8'h09; wdata = 8'h0A; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00; tick = 1'b0;
    expect_expiry(4, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule